// File: doc/BRIEF.md
# Interrupt CPU Interface Acknowledge Logic

This block sits between an interrupt distributor and one processor. Each cycle it looks at the pending vector and the per-source priority values that the distributor supplies. It works out which pending source is most urgent and raises an interrupt request to the processor when that source may preempt the work already in progress. Software talks to the block through a small register port. One register enables signalling and one holds a priority threshold. Reading the acknowledge register takes the winning interrupt: the read returns its ID and the source becomes active. Writing an ID to the end-of-interrupt register retires that source.

Source IDs equal the source index, and valid IDs run up to 510. Any value above 510 means that nothing was available, so a handler simply reads the acknowledge register again until it gets an ID below that limit. The block returns 1023 in that case. Every successful acknowledge also sends a one-cycle notice (`ack_valid_o`, `ack_id_o`) so that the distributor can clear the source's pending bit. The register port uses a valid/ready request channel and a valid/ready read-response channel. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. Only reads produce a response. `req_ready_o` is low while a response waits with `rsp_ready_i` low, and the response holds its data until it is taken. Register offsets on `req_addr_i` are: 0 control, 1 priority threshold, 2 acknowledge, 3 end-of-interrupt.

Top module: `cpuif_ack`

## Requirements
- R1: After reset `irq_o`, `rsp_valid_o` and `ack_valid_o` are low, and both the control register (offset 0) and the threshold register (offset 1) read back 0.
- R2: Bit 0 of the control register enables signalling. While it is 0, `irq_o` stays low and an acknowledge read returns 1023.
- R3: The threshold register holds PRIO_W bits and reads back the value written. Only sources whose priority value is numerically lower than the threshold are eligible.
- R4: Among the eligible pending sources that are not active, the one with the numerically lowest priority value wins. On a tie the lowest ID wins.
- R5: A read of offset 2 that returns an ID places the ID in the low bits of the response and marks that source active, which takes it out of selection. In the cycle the response appears, `ack_valid_o` pulses for one cycle with `ack_id_o` equal to that ID.
- R6: With no winner that may be signalled, an acknowledge read returns 1023, marks nothing active and gives no `ack_valid_o` pulse.
- R7: `irq_o` is high exactly when signalling is enabled and the winner's priority value is strictly lower than that of every active source. An active source of equal priority therefore blocks the request.
- R8: Writing the ID of an active source to offset 3 ends its active state, so that it can be signalled and acknowledged again while it is still pending.
- R9: An end-of-interrupt write naming an ID that is not active, including an ID of NUM_SRC or above, changes nothing.
- R10: While `rsp_valid_o` is high and `rsp_ready_i` is low, `req_ready_o` is low, a new request has no effect, and `rsp_data_o` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pend_i | input | NUM_SRC | Pending bit per source, from the distributor |
| prio_i | input | NUM_SRC*PRIO_W | Priority value per source, source i at bits [i*PRIO_W +: PRIO_W] |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 2 | Register offset |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_ready_i | input | 1 | Read response ready |
| rsp_data_o | output | DATA_W | Read response data |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_valid_o | output | 1 | One-cycle notice that a source was acknowledged |
| ack_id_o | output | 10 | ID of the acknowledged source |

## Verification
The bench sets the threshold exactly equal to a source's priority value, so a design that compared with less-or-equal would signal that source instead of returning 1023. It makes two sources tie on priority, which catches a selector that keeps the last match rather than the first. It nests three interrupts and retires them out of order, so that a design comparing against equal-or-lower running priority, or one that lets an unrelated end-of-interrupt clear state, would raise or drop `irq_o` at the wrong time. It also stalls the response channel, which shows a design that overwrites a waiting response or accepts a request it should refuse.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_PMASK = 2'd1,
    REG_ACK   = 2'd2,
    REG_EOI   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/cpuif_select.sv
// Finds the masked source with the smallest priority value; lowest index wins ties.
module cpuif_select #(
  parameter int N      = 16,
  parameter int PRIO_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        mask_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic                found_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic [PRIO_W-1:0]   prio_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    prio_o  = '1;
    for (int i = 0; i < N; i++) begin
      if (mask_i[i] && (!found_o || (prio_i[i*PRIO_W +: PRIO_W] < prio_o))) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  // R4
  winner_in_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (mask_i[idx_o] && (prio_i[idx_o*PRIO_W +: PRIO_W] == prio_o)));
endmodule

// File: rtl/cpuif_active.sv
// Active-state vector: set on acknowledge, cleared by a matching end-of-interrupt.
module cpuif_active #(
  parameter int N    = 16,
  parameter int ID_W = 10,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic             clr_i,
  input  logic [ID_W-1:0]  clr_id_i,
  output logic [N-1:0]     active_o
);
  logic clr_hit;
  assign clr_hit = clr_i && (clr_id_i < ID_W'(N)) && active_o[clr_id_i[IDX_W-1:0]];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      active_o <= '0;
    end else begin
      if (set_i)   active_o[set_idx_i] <= 1'b1;
      if (clr_hit) active_o[clr_id_i[IDX_W-1:0]] <= 1'b0;
    end
  end

  // R8
  one_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(active_o) <= $countones($past(active_o)) + 1) &&
    ($countones(active_o) + 1 >= $countones($past(active_o))));
  // R9
  eoi_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i && (clr_id_i >= ID_W'(N))) |=> $stable(active_o));
endmodule

// File: rtl/cpuif_ack.sv
module cpuif_ack
  import cpuif_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 8,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic                      req_write_i,
  input  logic [1:0]                req_addr_i,
  input  logic [DATA_W-1:0]         req_wdata_i,
  output logic                      rsp_valid_o,
  input  logic                      rsp_ready_i,
  output logic [DATA_W-1:0]         rsp_data_o,
  output logic                      irq_o,
  output logic                      ack_valid_o,
  output logic [ID_W-1:0]           ack_id_o
);
  logic              en_q;
  logic [PRIO_W-1:0] pmask_q;
  logic [NUM_SRC-1:0] active;
  logic [NUM_SRC-1:0] elig;
  logic              best_found, run_found;
  logic [IDX_W-1:0]  best_idx, run_idx;
  logic [PRIO_W-1:0] best_prio, run_prio;
  logic              signal_ok;
  logic              take, rd_take, wr_take, ack_take;
  logic [DATA_W-1:0] rd_data;
  reg_addr_e         addr;
  logic              unused_bits;

  assign unused_bits = ^{req_wdata_i, run_idx};
  assign addr = reg_addr_e'(req_addr_i);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign elig[g] = pend_i[g] && !active[g] && (prio_i[g*PRIO_W +: PRIO_W] < pmask_q);
  end

  cpuif_select #(.N(NUM_SRC), .PRIO_W(PRIO_W)) u_pick (
    .clk_i(clk_i), .rst_ni(rst_ni), .mask_i(elig), .prio_i(prio_i),
    .found_o(best_found), .idx_o(best_idx), .prio_o(best_prio));

  cpuif_select #(.N(NUM_SRC), .PRIO_W(PRIO_W)) u_run (
    .clk_i(clk_i), .rst_ni(rst_ni), .mask_i(active), .prio_i(prio_i),
    .found_o(run_found), .idx_o(run_idx), .prio_o(run_prio));

  assign signal_ok = en_q && best_found && (!run_found || (best_prio < run_prio));
  assign irq_o     = signal_ok;

  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign take     = req_valid_i && req_ready_o;
  assign rd_take  = take && !req_write_i;
  assign wr_take  = take && req_write_i;
  assign ack_take = rd_take && (addr == REG_ACK) && signal_ok;

  always_comb begin
    case (addr)
      REG_CTRL:  rd_data = DATA_W'(en_q);
      REG_PMASK: rd_data = DATA_W'(pmask_q);
      REG_ACK:   rd_data = signal_ok ? DATA_W'(best_idx) : DATA_W'(SPURIOUS_ID);
      default:   rd_data = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_q        <= 1'b0;
      pmask_q     <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
      ack_valid_o <= 1'b0;
      ack_id_o    <= '0;
    end else begin
      if (wr_take && addr == REG_CTRL)  en_q    <= req_wdata_i[0];
      if (wr_take && addr == REG_PMASK) pmask_q <= req_wdata_i[PRIO_W-1:0];
      if (rd_take) begin
        rsp_valid_o <= 1'b1;
        rsp_data_o  <= rd_data;
      end else if (rsp_ready_i) begin
        rsp_valid_o <= 1'b0;
      end
      ack_valid_o <= ack_take;
      if (ack_take) ack_id_o <= ID_W'(best_idx);
    end
  end

  cpuif_active #(.N(NUM_SRC), .ID_W(ID_W)) u_act (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(ack_take), .set_idx_i(best_idx),
    .clr_i(wr_take && addr == REG_EOI), .clr_id_i(req_wdata_i[ID_W-1:0]),
    .active_o(active));

  // R10
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));
  // R5
  ack_marks_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> (active[ack_id_o[IDX_W-1:0]] && rsp_valid_o &&
                     (rsp_data_o == DATA_W'(ack_id_o))));
  // R3
  irq_below_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (best_prio < pmask_q));
  // R7
  irq_preempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && run_found) |-> (best_prio < run_prio));
endmodule

// File: tb/cpuif_ack_tb.sv
module cpuif_ack_tb;
  localparam int N  = 16;
  localparam int PW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pend = '0;
  logic [N*PW-1:0] prio;
  logic          req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [1:0]    req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, irq, ack_valid;
  logic [DW-1:0] rsp_data;
  logic [9:0]    ack_id;
  int            errors = 0, checks = 0;
  bit            done = 1'b0;
  logic [DW-1:0] rd;
  logic          last_ackv;
  logic [9:0]    last_ackid;

  always #5 clk = ~clk;

  cpuif_ack #(.NUM_SRC(N), .PRIO_W(PW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .prio_i(prio),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data),
    .irq_o(irq), .ack_valid_o(ack_valid), .ack_id_o(ack_id));

  // priority of source i: ((i*5) mod 8) << 4
  always_comb
    for (int i = 0; i < N; i++) prio[i*PW +: PW] = PW'(((i * 5) % 8) << 4);

  // {pend, threshold, expected acknowledge value}
  localparam logic [33:0] VEC [0:10] = '{
    {16'h0002, 8'hF0, 10'd1},
    {16'h0102, 8'hF0, 10'd8},
    {16'h0101, 8'hF0, 10'd0},
    {16'h2020, 8'hF0, 10'd5},
    {16'h0808, 8'h70, 10'd1023},
    {16'h0808, 8'h71, 10'd3},
    {16'h8004, 8'h30, 10'd2},
    {16'h8000, 8'h30, 10'd1023},
    {16'h0000, 8'hF0, 10'd1023},
    {16'hFFFF, 8'hF0, 10'd0},
    {16'h4840, 8'hF0, 10'd6}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_data; last_ackv = ack_valid; last_ackid = ack_id;
  endtask

  task automatic ack_read(input string tag, input logic [9:0] exp);
    xfer(1'b0, 2'd2, '0);
    check(tag, rd, DW'(exp));
    check({tag, " ack pulse"}, last_ackv, (exp != 10'd1023));
    if (exp != 10'd1023) check({tag, " ack id"}, last_ackid, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 ack_valid", ack_valid, 0);
    xfer(1'b0, 2'd0, '0); check("R1 ctrl", rd, 0);
    xfer(1'b0, 2'd1, '0); check("R1 pmask", rd, 0);

    // R2 disabled: no request, spurious acknowledge
    xfer(1'b1, 2'd1, 16'h00F0);
    pend = 16'hFFFF;
    @(negedge clk); check("R2 irq disabled", irq, 0);
    ack_read("R2 ack disabled", 10'd1023);
    xfer(1'b1, 2'd0, 16'h0001);
    check("R2 irq enabled", irq, 1);
    // R3 readback
    xfer(1'b0, 2'd0, '0); check("R3 ctrl read", rd, 1);
    xfer(1'b0, 2'd1, '0); check("R3 pmask read", rd, 16'h00F0);

    // R4 R3 R6 vector table
    for (int v = 0; v < 11; v++) begin
      pend = VEC[v][33:18];
      xfer(1'b1, 2'd1, DW'(VEC[v][17:10]));
      check($sformatf("R4 row%0d irq", v), irq, (VEC[v][9:0] != 10'd1023));
      ack_read($sformatf("R4 row%0d ack", v), VEC[v][9:0]);
      if (VEC[v][9:0] != 10'd1023) xfer(1'b1, 2'd3, DW'(VEC[v][9:0]));
    end
    pend = '0;
    xfer(1'b1, 2'd1, 16'h00F0);

    // R7 nesting, R5 active excluded, R8 retire out of order
    pend = 16'h0024;
    @(negedge clk); check("R7 irq two pending", irq, 1);
    ack_read("R5 ack first", 10'd5);
    check("R7 lower priority blocked", irq, 0);
    ack_read("R6 ack blocked", 10'd1023);
    pend = 16'h0025;
    @(negedge clk); check("R7 preempt irq", irq, 1);
    ack_read("R5 ack nested", 10'd0);
    pend = 16'h0004;
    @(negedge clk); check("R7 two active", irq, 0);
    xfer(1'b1, 2'd3, 16'd0);
    check("R8 eoi inner", irq, 0);
    xfer(1'b1, 2'd3, 16'd5);
    check("R8 eoi outer", irq, 1);
    ack_read("R5 ack third", 10'd2);
    pend = '0;
    xfer(1'b1, 2'd3, 16'd2);
    check("R8 all retired", irq, 0);

    // R9 ignored end-of-interrupt, R7 equal priority blocks
    pend = 16'h0202;
    ack_read("R4 ack tie", 10'd1);
    check("R7 equal priority blocked", irq, 0);
    xfer(1'b1, 2'd3, 16'd7);
    check("R9 eoi not active", irq, 0);
    xfer(1'b1, 2'd3, 16'd600);
    check("R9 eoi out of range", irq, 0);
    ack_read("R9 still blocked", 10'd1023);
    xfer(1'b1, 2'd3, 16'd1);
    check("R8 eoi reopens", irq, 1);
    ack_read("R8 reacknowledge", 10'd1);
    xfer(1'b1, 2'd3, 16'd1);
    pend = '0;

    // R10 back-pressure on the response channel
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 2'd0;
    @(negedge clk);
    req_write = 1'b1; req_wdata = 16'h0000;
    check("R10 rsp valid", rsp_valid, 1);
    check("R10 ready low", req_ready, 0);
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    check("R10 held valid", rsp_valid, 1);
    check("R10 held data", rsp_data, 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R10 drained", rsp_valid, 0);
    xfer(1'b0, 2'd0, '0);
    check("R10 blocked write had no effect", rd, 1);

    // R2 disable while pending
    pend = 16'h0001;
    @(negedge clk); check("R2 irq on", irq, 1);
    xfer(1'b1, 2'd0, 16'h0000);
    check("R2 irq off", irq, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule